// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial front end of a small nonvolatile word memory and carries out the commands that change its contents. The front end shifts in a frame, decodes it and presents the opcode, the word address and the data word on a command stream. For the two commands that gate programming, the block updates its write-enable latch at once. For the four commands that alter the array, the block records the command and waits for the select line to drop. If the select line drops before any further serial clock rise, a self-timed busy period starts. The array is updated when that period ends. It updates one word or, for the bulk forms, every word.

While a cycle is in progress, or after it has finished, raising the select line shows a status bit that the front end places on its data-out pin: 0 means busy and 1 means ready. The status stays visible until the host clocks a dummy 1 in on the data-in line. The status output then goes undriven on the next serial clock fall. The busy length is a clock-count parameter that stands in for the program pulse width. The block also offers a plain read port onto the array. That port works whatever the state of the enable latch.

The command stream uses valid/ready. A command transfers on a clock where both are high. Ready is high only while the block is idle. A serial frame cannot be held back, so the front end drops a command offered while ready is low, and that command has no effect.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: Out of reset the enable latch is clear, no cycle runs, `busy_o` and `status_oe_o` are 0 and `cmd_ready_o` is 1. Reset leaves the array contents as they were.
- R2: The opcode field is decoded as follows: 0 clears one word, 1 writes one word, 2 clears all words, 3 writes all words, 4 sets the enable latch and 5 clears it. While the latch is clear, opcodes 0 to 3 are accepted and discarded, so no busy period follows and the array does not change. Reads return stored data in either latch state.
- R3: Once set, the enable latch allows any number of program cycles. It is cleared only by opcode 5 or by reset.
- R4: An accepted opcode 0 to 3 with the latch set starts a cycle when `cs_i` is seen low before any `sk_rise_i`. If `sk_rise_i` arrives first while `cs_i` is high, the command is cancelled and no cycle runs.
- R5: Opcode 0 sets the addressed word to all ones. Opcode 2 sets every word to all ones.
- R6: `busy_o` stays high for exactly PROG_CYCLES clocks, starting on the clock after `cs_i` is sampled low. The array change is visible on the read port once `busy_o` has dropped.
- R7: Opcode 1 stores its data over any previous contents, with no prior clear needed. Opcode 3 stores the same data in every word.
- R8: After a cycle has started, `status_oe_o` is high whenever `cs_i` is high. `status_do_o` reads 0 while busy and 1 when done. `status_oe_o` is 0 whenever `cs_i` is low.
- R9: While status is shown, an `sk_rise_i` with `di_i` at 1 followed by `sk_fall_i` turns `status_oe_o` off from the clock after the fall. A 0 on `di_i` leaves the status shown.
- R10: While busy, `cmd_ready_o` is 0 and a command offered on the stream neither changes the array nor changes the enable latch.
- R11: Opcodes 6 and 7 are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs_i | input | 1 | Chip select level, synchronised to clk |
| sk_rise_i | input | 1 | One-clock pulse per serial clock rise while selected |
| sk_fall_i | input | 1 | One-clock pulse per serial clock fall |
| di_i | input | 1 | Serial data-in level, valid with sk_rise_i |
| cmd_valid_i | input | 1 | Decoded command present |
| cmd_ready_o | output | 1 | Block can take a command (idle) |
| cmd_op_i | input | 3 | Opcode, encoding in R2 |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_data_i | input | DATA_W | Data word for single or bulk write |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | DATA_W | Read port data, combinational |
| busy_o | output | 1 | Program cycle in progress |
| status_oe_o | output | 1 | Front end should drive status on data-out |
| status_do_o | output | 1 | Status value: 0 busy, 1 ready |

## Verification
The assertions check on every cycle that a busy period starts only with the enable latch set and only after select was sampled low. They also check that each busy period lasts the parameter length, that status is never driven while deselected, that status appears as soon as a cycle starts under select, and that the latch cannot move during a busy period. Only the bench's scenarios can show the effects on the array contents. These are the single and bulk clears and writes, a write over old data, commands cancelled by an early serial clock, commands dropped while disabled or busy, and contents kept across reset. The same holds for the dummy-1 and dummy-0 status sequences.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [2:0] {
    OP_CLR_ONE = 3'd0,
    OP_WR_ONE  = 3'd1,
    OP_CLR_ALL = 3'd2,
    OP_WR_ALL  = 3'd3,
    OP_LOCK_ON = 3'd4,
    OP_LOCK_OFF = 3'd5
  } pce_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } pce_state_e;

  // opcodes 0..3 alter the array
  function automatic logic alters_array(input logic [2:0] op);
    return op <= 3'd3;
  endfunction

endpackage

// File: rtl/pce_seq.sv
module pce_seq #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              wel_o,
  output logic              start_o,
  output logic              commit_o,
  output logic              commit_all_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  import pce_pkg::*;

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  pce_state_e        state_q;
  logic              wel_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wel_q   <= 1'b0;
      op_q    <= 3'd0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_fire_i) begin
            if (cmd_op_i == OP_LOCK_ON) begin
              wel_q <= 1'b1;
            end else if (cmd_op_i == OP_LOCK_OFF) begin
              wel_q <= 1'b0;
            end else if (alters_array(cmd_op_i) && wel_q) begin
              op_q    <= cmd_op_i;
              addr_q  <= cmd_addr_i;
              data_q  <= cmd_data_i;
              state_q <= ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          // select must drop before the next serial clock rise
          if (!cs_i) begin
            state_q <= ST_BUSY;
            cnt_q   <= CNT_LOAD;
          end else if (sk_rise_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic is_clear;
  assign is_clear = (op_q == OP_CLR_ONE) || (op_q == OP_CLR_ALL);

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign busy_o        = (state_q == ST_BUSY);
  assign wel_o         = wel_q;
  assign start_o       = (state_q == ST_ARMED) && !cs_i;
  assign commit_o      = (state_q == ST_BUSY) && (cnt_q == '0);
  assign commit_all_o  = (op_q == OP_CLR_ALL) || (op_q == OP_WR_ALL);
  assign commit_addr_o = addr_q;
  assign commit_data_o = is_clear ? {DATA_W{1'b1}} : data_q;

endmodule

// File: rtl/pce_status.sv
module pce_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_rise_i,
  input  logic sk_fall_i,
  input  logic di_i,
  input  logic start_i,
  input  logic busy_i,
  output logic status_oe_o,
  output logic status_do_o
);

  logic shown_q;
  logic drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (start_i) begin
      shown_q <= 1'b1;
      drop_q  <= 1'b0;
    end else begin
      if (shown_q && cs_i && sk_rise_i && di_i) begin
        drop_q <= 1'b1;
      end
      if (sk_fall_i && drop_q) begin
        shown_q <= 1'b0;
        drop_q  <= 1'b0;
      end
    end
  end

  assign status_oe_o = shown_q && cs_i;
  assign status_do_o = !busy_i;

endmodule

// File: rtl/pce_array.sv
module pce_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we_i && (all_i || (addr_i == ADDR_W'(w)));
    // contents are nonvolatile: no reset
    always_ff @(posedge clk) begin
      if (hit) begin
        word_q <= data_i;
      end
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];

endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  logic              sk_fall_i,
  input  logic              di_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              status_oe_o,
  output logic              status_do_o
);

  logic              cmd_fire;
  logic              wel;
  logic              start;
  logic              commit;
  logic              commit_all;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;

  assign cmd_fire = cmd_valid_i && cmd_ready_o;

  pce_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_fire_i    (cmd_fire),
    .cmd_op_i      (cmd_op_i),
    .cmd_addr_i    (cmd_addr_i),
    .cmd_data_i    (cmd_data_i),
    .cs_i          (cs_i),
    .sk_rise_i     (sk_rise_i),
    .cmd_ready_o   (cmd_ready_o),
    .busy_o        (busy_o),
    .wel_o         (wel),
    .start_o       (start),
    .commit_o      (commit),
    .commit_all_o  (commit_all),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data)
  );

  pce_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs_i),
    .sk_rise_i   (sk_rise_i),
    .sk_fall_i   (sk_fall_i),
    .di_i        (di_i),
    .start_i     (start),
    .busy_i      (busy_o),
    .status_oe_o (status_oe_o),
    .status_do_o (status_do_o)
  );

  pce_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk       (clk),
    .we_i      (commit),
    .all_i     (commit_all),
    .addr_i    (commit_addr),
    .data_i    (commit_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic busy_o,
  input logic status_oe_o,
  input logic wel
);

  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
    end else if (busy_o) begin
      busy_len <= busy_len + 1'b1;
    end else begin
      busy_len <= '0;
    end
  end

  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> wel);

  assert_start_after_cs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(cs_i));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == 32'(PROG_CYCLES)));

  assert_status_off_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !status_oe_o);

  assert_status_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && cs_i) |-> status_oe_o);

  assert_wel_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(wel));

endmodule

bind prog_cycle_ctrl pce_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_i        (cs_i),
  .busy_o      (busy_o),
  .status_oe_o (status_oe_o),
  .wel         (wel)
);

// File: tb/sim_prog_cycle_ctrl.sv
module sim_prog_cycle_ctrl;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PC = 40;
  localparam int WORDS = 1 << AW;
  localparam logic [2:0] K_CLR1 = 3'd0, K_WR1 = 3'd1, K_CLRA = 3'd2,
                         K_WRA = 3'd3, K_ON = 3'd4, K_OFF = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, skr = 1'b0, skf = 1'b0, di = 1'b0;
  logic cvalid = 1'b0;
  logic [2:0] cop = 3'd0;
  logic [AW-1:0] caddr = '0, raddr = '0;
  logic [DW-1:0] cdata = '0;
  logic cready, busy, soe, sdo;
  logic [DW-1:0] rdata;

  prog_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_rise_i(skr), .sk_fall_i(skf),
    .di_i(di), .cmd_valid_i(cvalid), .cmd_ready_o(cready), .cmd_op_i(cop),
    .cmd_addr_i(caddr), .cmd_data_i(cdata), .rd_addr_i(raddr),
    .rd_data_o(rdata), .busy_o(busy), .status_oe_o(soe), .status_do_o(sdo)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit m_wel = 1'b0;
  bit m_known = 1'b0;
  logic [DW-1:0] m_mem [WORDS];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit expect_cycle(input logic [2:0] op, input bit cancel);
    return m_wel && (op <= 3'd3) && !cancel;
  endfunction

  function automatic logic [DW-1:0] new_value(input logic [2:0] op, input logic [DW-1:0] d);
    return (op == K_CLR1 || op == K_CLRA) ? {DW{1'b1}} : d;
  endfunction

  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int guard = 0;
    cs = 1'b1;
    while (!cready && guard < 1000) begin guard++; tick(); end
    cvalid = 1'b1; cop = op; caddr = a; cdata = d;
    tick();
    cvalid = 1'b0;
  endtask

  task automatic check_mem(input string req);
    if (m_known) begin
      for (int i = 0; i < WORDS; i++) begin
        raddr = AW'(i);
        #1;
        chk(rdata == m_mem[i], req, 32'(rdata), 32'(m_mem[i]));
      end
    end
  endtask

  // one full program-type transaction, with optional cancel, busy probe and dummy-0 test
  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit cancel, input bit probe, input bit dummy0, input string req);
    bit exp_cyc;
    int n;
    exp_cyc = expect_cycle(op, cancel);
    send_cmd(op, a, d);
    if (op == K_ON) m_wel = 1'b1;
    if (op == K_OFF) m_wel = 1'b0;
    if (cancel) begin
      skr = 1'b1; di = 1'b0;
      tick();
      skr = 1'b0;
    end
    cs = 1'b0;
    tick();
    chk(busy == exp_cyc, req, 32'(busy), 32'(exp_cyc));
    cs = 1'b1;
    tick();
    if (exp_cyc) begin
      chk(soe && !sdo, "R8 busy status", {30'd0, soe, sdo}, 32'h2);
      n = 1;
      while (busy && n < 1000) begin
        n++;
        if (probe && n == 5) begin
          chk(cready == 1'b0, "R10 ready low while busy", 32'(cready), 32'h0);
          cvalid = 1'b1; cop = K_WR1; caddr = a ^ AW'(1); cdata = 16'h0BAD;
        end else begin
          cvalid = 1'b0;
        end
        tick();
      end
      cvalid = 1'b0;
      chk(n == PC, "R6 busy length", 32'(n), 32'(PC));
      chk(soe && sdo, "R8 ready status", {30'd0, soe, sdo}, 32'h3);
      if (op == K_CLRA || op == K_WRA) begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = new_value(op, d);
        m_known = 1'b1;
      end else begin
        m_mem[a] = new_value(op, d);
      end
      if (dummy0) begin
        skr = 1'b1; di = 1'b0; tick();
        skr = 1'b0; skf = 1'b1; tick();
        skf = 1'b0;
        chk(soe == 1'b1, "R9 dummy 0 keeps status", 32'(soe), 32'h1);
      end
      skr = 1'b1; di = 1'b1; tick();
      skr = 1'b0; di = 1'b0; skf = 1'b1; tick();
      skf = 1'b0;
      chk(soe == 1'b0, "R9 dummy 1 releases status", 32'(soe), 32'h0);
    end else begin
      chk(soe == 1'b0, req, 32'(soe), 32'h0);
    end
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    void'($urandom(32'd2718));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    chk(cready == 1'b1 && busy == 1'b0 && soe == 1'b0, "R1 reset state",
        {29'd0, cready, busy, soe}, 32'h4);
    // R2: disabled write is discarded
    run_op(K_WR1, 6'd3, 16'h1234, 0, 0, 0, "R2 disabled write no cycle");
    // enable, bulk clear
    run_op(K_ON, 6'd0, 16'h0, 0, 0, 0, "R2 enable no cycle");
    run_op(K_CLRA, 6'd0, 16'h0, 0, 0, 0, "R5 bulk clear starts");
    check_mem("R5 all words ones");
    // R7: write then overwrite without clear
    run_op(K_WR1, 6'd5, 16'hA5A5, 0, 0, 1, "R7 write starts");
    run_op(K_WR1, 6'd5, 16'h5A5A, 0, 0, 0, "R3 second write still enabled");
    raddr = 6'd5; #1;
    chk(rdata == 16'h5A5A, "R7 overwrite", 32'(rdata), 32'h5A5A);
    // R5 single clear
    run_op(K_CLR1, 6'd5, 16'h0, 0, 0, 0, "R5 clear starts");
    raddr = 6'd5; #1;
    chk(rdata == 16'hFFFF, "R5 word ones", 32'(rdata), 32'hFFFF);
    // R4 cancel by early clock
    run_op(K_WR1, 6'd9, 16'h0F0F, 1, 0, 0, "R4 cancel no cycle");
    check_mem("R4 cancel leaves array");
    // R10 command while busy dropped
    run_op(K_WR1, 6'd12, 16'hC3C3, 0, 1, 0, "R10 write starts");
    check_mem("R10 busy command dropped");
    // R2 disable, reads unaffected
    run_op(K_OFF, 6'd0, 16'h0, 0, 0, 0, "R2 disable no cycle");
    run_op(K_WRA, 6'd0, 16'h7777, 0, 0, 0, "R2 disabled bulk write no cycle");
    check_mem("R2 reads while disabled");
    // R11 unused opcode
    run_op(K_ON, 6'd0, 16'h0, 0, 0, 0, "R3 enable again");
    run_op(3'd6, 6'd2, 16'h1111, 0, 0, 0, "R11 opcode 6 no cycle");
    run_op(3'd7, 6'd2, 16'h2222, 0, 0, 0, "R11 opcode 7 no cycle");
    check_mem("R11 array unchanged");
    // R1/R3 reset clears enable, keeps array
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; m_wel = 1'b0; tick();
    chk(cready == 1'b1 && busy == 1'b0 && soe == 1'b0, "R1 state after reset",
        {29'd0, cready, busy, soe}, 32'h4);
    run_op(K_WR1, 6'd12, 16'h4444, 0, 0, 0, "R3 reset clears enable");
    check_mem("R1 array kept over reset");
    // R7 bulk write
    run_op(K_ON, 6'd0, 16'h0, 0, 0, 0, "R2 enable no cycle");
    run_op(K_WRA, 6'd0, 16'h3C5A, 0, 0, 0, "R7 bulk write starts");
    check_mem("R7 all words written");
    // random mix
    for (int it = 0; it < 40; it++) begin
      r = $urandom_range(0, 9);
      ra = AW'($urandom_range(0, WORDS - 1));
      rd = DW'($urandom);
      if (!m_wel && $urandom_range(0, 1) == 1) r = 7;
      case (r)
        0, 1, 2: run_op(K_WR1, ra, rd, 0, 0, 0, "R7 random write");
        3: run_op(K_CLR1, ra, rd, 0, 0, 0, "R5 random clear");
        4: run_op(K_CLRA, ra, rd, 0, 0, 0, "R5 random bulk clear");
        5: run_op(K_WRA, ra, rd, 0, 0, 0, "R7 random bulk write");
        6: run_op(K_OFF, ra, rd, 0, 0, 0, "R2 random disable");
        7: run_op(K_ON, ra, rd, 0, 0, 0, "R3 random enable");
        default: run_op(K_WR1, ra, rd, 1, 0, 0, "R4 random cancel");
      endcase
      for (int k = 0; k < 4; k++) begin
        raddr = AW'($urandom_range(0, WORDS - 1));
        #1;
        chk(rdata == m_mem[raddr], "R7 random readback", 32'(rdata), 32'(m_mem[raddr]));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule